// File: doc/BRIEF.md
# Host I/O Decode and Interrupt Router

This block sits on the host side of an ISA add-in card. It compares the full 16-bit host I/O address with a programmable 13-bit base, so the card owns one eight-address register window with no aliases. While a host read or write strobe is active and the address falls inside the window, it raises a card-select and passes on the offset within the window. It also drives nine interrupt request pins. Each pin has its own output enable, at most one enable is ever active, and every other pin is left at high impedance.

The base and interrupt choice come from one of two register sets. The plug-and-play set is normally written by the host configuration sequence. The default set is written by the DSP and is used in standard mode, that is, when both the plug-and-play enable input and the PCMCIA select input are low. The DSP can take the plug-and-play logic offline and write the plug-and-play set itself. While it is offline, the host configuration writes to that set are ignored. In PCMCIA mode only the pin shared with IRQ9 is enabled. The level on the enabled pin is a DSP control bit, gated by a mask bit in the host control register.

Top module: `host_io_router`

## Requirements
- R1: `card_sel` is 1 exactly when `host_rd` or `host_wr` is 1 and `host_addr[15:3]` equals the effective base. All 16 address bits take part: bits 15:3 are compared and bits 2:0 appear on `reg_ofs`.
- R2: `irq_oe` bits 0 to 8 belong to IRQ 3, 4, 5, 7, 9, 10, 11, 12 and 15, in that order. An effective 4-bit code equal to one of these numbers enables only that pin. Codes 0, 1, 2, 6, 8, 13 and 14 enable no pin. At most one enable is ever 1.
- R3: The default set (base, code) is effective when both `pnp_en` and `pcmcia_mode` are 0. In every other case the plug-and-play set is effective. The mode inputs act in the same cycle.
- R4: A DSP write (`dsp_wr`=1) takes effect at the next clock edge. Index 0 loads the default base from `dsp_wdata[12:0]`. Index 1 loads the default code from `dsp_wdata[3:0]`. Index 2 loads the control register: bit 0 is the interrupt level and bit 1 is the offline flag.
- R5: A host configuration write (`cfg_wr`=1) takes effect at the next clock edge. Index 0 loads the plug-and-play base from `cfg_data[12:0]`. Index 1 loads the plug-and-play code from `cfg_data[3:0]`. Index 2 loads the host mask from `cfg_data[0]`. Writes to index 0 and index 1 are ignored while the offline flag is 1.
- R6: DSP write index 3 loads the plug-and-play base and index 4 loads the plug-and-play code. Both are accepted only while the offline flag is already 1.
- R7: When `pcmcia_mode` is 1, only `irq_oe` bit 4 (the IRQ9 pin) is enabled, whatever the code.
- R8: The enabled pin drives the interrupt level AND NOT the host mask. Every pin that is not enabled drives 0 on `irq_out`.
- R9: Reset clears every register to 0. After reset no enable is active and the effective base is 0.
- R10: `pnp_level` follows `pnp_en`, so the DSP can read the level of the mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host I/O address |
| host_rd | input | 1 | Host I/O read strobe, active high |
| host_wr | input | 1 | Host I/O write strobe, active high |
| pnp_en | input | 1 | Plug-and-play enable (high when the pin is left open) |
| pcmcia_mode | input | 1 | 1 selects PCMCIA mode, 0 selects ISA |
| cfg_wr | input | 1 | Host configuration register write |
| cfg_idx | input | 2 | Host configuration register index |
| cfg_data | input | 13 | Host configuration write data |
| dsp_wr | input | 1 | DSP register write |
| dsp_idx | input | 3 | DSP register index |
| dsp_wdata | input | 13 | DSP write data |
| card_sel | output | 1 | Card window selected |
| reg_ofs | output | 3 | Register offset inside the window |
| irq_oe | output | 9 | Per-pin interrupt output enables |
| irq_out | output | 9 | Per-pin interrupt levels |
| pnp_level | output | 1 | Level of the plug-and-play enable input, for the DSP to read |

## Verification
`card_sel`, `reg_ofs` and the mode-driven choice of register set are combinational, so they are due in the same cycle as the address, strobe or mode change. A register write changes the enables, levels and decode base one edge after it is presented. The bench drives every input on a falling edge and lets exactly one rising edge pass for each write. It samples all results on the next falling edge, so it never reads a value while that value is changing.

// File: rtl/hio_pkg.sv
package hio_pkg;

    localparam int ADDR_W  = 16;
    localparam int BASE_W  = 13;
    localparam int SEL_W   = 4;
    localparam int NUM_IRQ = 9;
    localparam int PCM_PIN = 4;

    typedef logic [BASE_W-1:0] base_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        base_t base;
        sel_t  sel;
    } route_t;

    typedef enum logic [2:0] {
        D_DEF_BASE = 3'd0,
        D_DEF_SEL  = 3'd1,
        D_CTRL     = 3'd2,
        D_PNP_BASE = 3'd3,
        D_PNP_SEL  = 3'd4
    } dsp_idx_e;

    typedef enum logic [1:0] {
        H_PNP_BASE = 2'd0,
        H_PNP_SEL  = 2'd1,
        H_CTRL     = 2'd2
    } host_idx_e;

    // Interrupt number carried by each output pin, lowest pin first.
    function automatic int pin_irq(input int pin);
        case (pin)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 7;
            4:       return 9;
            5:       return 10;
            6:       return 11;
            7:       return 12;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/hio_cfg_regs.sv
module hio_cfg_regs
    import hio_pkg::*;
#(
    parameter int DATA_W = BASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dsp_wr,
    input  logic [2:0]        dsp_idx,
    input  logic [DATA_W-1:0] dsp_wdata,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    output route_t            def_route,
    output route_t            pnp_route,
    output logic              irq_level,
    output logic              offline,
    output logic              host_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            def_route <= '0;
            pnp_route <= '0;
            irq_level <= 1'b0;
            offline   <= 1'b0;
            host_mask <= 1'b0;
        end else begin
            if (dsp_wr) begin
                case (dsp_idx)
                    D_DEF_BASE: def_route.base <= dsp_wdata[BASE_W-1:0];
                    D_DEF_SEL:  def_route.sel  <= dsp_wdata[SEL_W-1:0];
                    D_CTRL: begin
                        irq_level <= dsp_wdata[0];
                        offline   <= dsp_wdata[1];
                    end
                    D_PNP_BASE: if (offline) pnp_route.base <= dsp_wdata[BASE_W-1:0];
                    D_PNP_SEL:  if (offline) pnp_route.sel  <= dsp_wdata[SEL_W-1:0];
                    default: ;
                endcase
            end
            if (cfg_wr) begin
                case (cfg_idx)
                    H_PNP_BASE: if (!offline) pnp_route.base <= cfg_data[BASE_W-1:0];
                    H_PNP_SEL:  if (!offline) pnp_route.sel  <= cfg_data[SEL_W-1:0];
                    H_CTRL:     host_mask <= cfg_data[0];
                    default: ;
                endcase
            end
        end
    end

    // R5: host configuration cannot move the base while the DSP holds it
    p_host_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (offline && cfg_wr && cfg_idx == H_PNP_BASE && !(dsp_wr && dsp_idx == D_PNP_BASE))
        |=> $stable(pnp_route.base));

    // R6: the DSP cannot write the plug-and-play set while it is online
    p_dsp_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (!offline && dsp_wr && dsp_idx == D_PNP_SEL && !(cfg_wr && cfg_idx == H_PNP_SEL))
        |=> $stable(pnp_route.sel));

endmodule

// File: rtl/hio_addr_match.sv
module hio_addr_match #(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 13,
    localparam int OFS_W = ADDR_W - BASE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BASE_W-1:0] base,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:OFS_W] == base);
        hit       = (rd | wr) & in_window;
        ofs       = addr[OFS_W-1:0];
    end

endmodule

// File: rtl/hio_irq_router.sv
module hio_irq_router
    import hio_pkg::*;
#(
    parameter int N_PIN  = NUM_IRQ,
    parameter int CODE_W = SEL_W,
    parameter int PCM_IX = PCM_PIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              pcm_mode,
    input  logic              level,
    output logic [N_PIN-1:0]  oe,
    output logic [N_PIN-1:0]  out
);

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        localparam logic [CODE_W-1:0] PIN_CODE = CODE_W'(pin_irq(i));
        localparam bit                IS_PCM   = (i == PCM_IX);
        always_comb begin
            oe[i]  = pcm_mode ? IS_PCM : (code == PIN_CODE);
            out[i] = oe[i] & level;
        end
    end

    // R2: never more than one driven pin
    p_single_oe_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oe));

    // R8: a pin without enable never carries a high level
    p_quiet_pins_r8: assert property (@(posedge clk) disable iff (rst)
        (out & ~oe) == '0);

endmodule

// File: rtl/host_io_router.sv
module host_io_router
    import hio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic                 pnp_en,
    input  logic                 pcmcia_mode,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_idx,
    input  logic [BASE_W-1:0]    cfg_data,
    input  logic                 dsp_wr,
    input  logic [2:0]           dsp_idx,
    input  logic [BASE_W-1:0]    dsp_wdata,
    output logic                 card_sel,
    output logic [ADDR_W-BASE_W-1:0] reg_ofs,
    output logic [NUM_IRQ-1:0]   irq_oe,
    output logic [NUM_IRQ-1:0]   irq_out,
    output logic                 pnp_level
);

    route_t def_route, pnp_route, eff_route;
    logic   irq_level, offline, host_mask, use_default, pin_level;

    hio_cfg_regs #(.DATA_W(BASE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dsp_wr    (dsp_wr),
        .dsp_idx   (dsp_idx),
        .dsp_wdata (dsp_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .def_route (def_route),
        .pnp_route (pnp_route),
        .irq_level (irq_level),
        .offline   (offline),
        .host_mask (host_mask)
    );

    always_comb begin
        use_default = !pnp_en && !pcmcia_mode;
        eff_route   = use_default ? def_route : pnp_route;
        pin_level   = irq_level & ~host_mask;
        pnp_level   = pnp_en;
    end

    hio_addr_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_match (
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .base (eff_route.base),
        .hit  (card_sel),
        .ofs  (reg_ofs)
    );

    hio_irq_router #(.N_PIN(NUM_IRQ), .CODE_W(SEL_W), .PCM_IX(PCM_PIN)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .code     (eff_route.sel),
        .pcm_mode (pcmcia_mode),
        .level    (pin_level),
        .oe       (irq_oe),
        .out      (irq_out)
    );

    // R1: no selection without a host strobe
    p_sel_needs_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        card_sel |-> (host_rd || host_wr));

    // R7: PCMCIA mode leaves only the IRQ9 pin enabled
    p_pcm_single_r7: assert property (@(posedge clk) disable iff (rst)
        pcmcia_mode |-> (irq_oe == NUM_IRQ'(1 << PCM_PIN)));

    // R8: a set host mask silences every pin
    p_mask_silent_r8: assert property (@(posedge clk) disable iff (rst)
        host_mask |-> (irq_out == '0));

    // R9: one cycle after reset no enable is active
    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) && !pcmcia_mode |-> (irq_oe == '0));

endmodule

// File: tb/tb_host_io_router.sv
module tb_host_io_router;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr;
    logic        host_rd, host_wr, pnp_en, pcmcia_mode;
    logic        cfg_wr, dsp_wr;
    logic [1:0]  cfg_idx;
    logic [2:0]  dsp_idx;
    logic [12:0] cfg_data, dsp_wdata;
    logic        card_sel, pnp_level;
    logic [2:0]  reg_ofs;
    logic [8:0]  irq_oe, irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    host_io_router dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .pnp_en(pnp_en), .pcmcia_mode(pcmcia_mode),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .dsp_wr(dsp_wr), .dsp_idx(dsp_idx), .dsp_wdata(dsp_wdata),
        .card_sel(card_sel), .reg_ofs(reg_ofs), .irq_oe(irq_oe),
        .irq_out(irq_out), .pnp_level(pnp_level)
    );

    // {pnp_en, pcmcia, rd, wr, addr[15:0], exp_sel, exp_oe[8:0]}
    // default set: base 0x0A5 (window 0x0528..0x052F), code 5
    // plug-and-play set: base 0x1F00 (window 0xF800..0xF807), code 11
    localparam logic [29:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h0528, 1'b1, 9'h004},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h052F, 1'b1, 9'h004},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h0530, 1'b0, 9'h004},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'hF800, 1'b0, 9'h004},
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h0528, 1'b0, 9'h004},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'hF800, 1'b1, 9'h040},
        {1'b1, 1'b0, 1'b0, 1'b1, 16'hF807, 1'b1, 9'h040},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0528, 1'b0, 9'h040},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'hF803, 1'b1, 9'h010},
        {1'b1, 1'b1, 1'b0, 1'b1, 16'hF805, 1'b1, 9'h010},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h7800, 1'b0, 9'h040},
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h8528, 1'b0, 9'h004}
    };

    function automatic logic [8:0] exp_pins(input logic [3:0] code);
        case (code)
            4'd3:    return 9'h001;
            4'd4:    return 9'h002;
            4'd5:    return 9'h004;
            4'd7:    return 9'h008;
            4'd9:    return 9'h010;
            4'd10:   return 9'h020;
            4'd11:   return 9'h040;
            4'd12:   return 9'h080;
            4'd15:   return 9'h100;
            default: return 9'h000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic dsp_write(input logic [2:0] idx, input logic [12:0] d);
        @(negedge clk);
        dsp_wr = 1'b1; dsp_idx = idx; dsp_wdata = d;
        @(negedge clk);
        dsp_wr = 1'b0;
    endtask

    task automatic host_cfg(input logic [1:0] idx, input logic [12:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic bus(input logic p, input logic c, input logic r, input logic w,
                       input logic [15:0] a);
        pnp_en = p; pcmcia_mode = c; host_rd = r; host_wr = w; host_addr = a;
        #1;
    endtask

    initial begin
        rst = 1'b1; host_addr = '0; host_rd = 0; host_wr = 0; pnp_en = 1; pcmcia_mode = 0;
        cfg_wr = 0; cfg_idx = '0; cfg_data = '0; dsp_wr = 0; dsp_idx = '0; dsp_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: cleared registers, base 0, no enable
        bus(1, 0, 1, 0, 16'h0003);
        chk("R9 sel at base 0", card_sel, 1);
        chk("R1 offset", reg_ofs, 3);
        chk("R9 no enable", irq_oe, 0);
        chk("R9 no level", irq_out, 0);
        chk("R10 level high", pnp_level, 1);
        bus(0, 0, 0, 0, 16'h0003);
        chk("R10 level low", pnp_level, 0);

        // R4, R5: load both sets
        dsp_write(3'd0, 13'h00A5);
        dsp_write(3'd1, 13'd5);
        dsp_write(3'd2, 13'h0001);
        host_cfg(2'd0, 13'h1F00);
        host_cfg(2'd1, 13'd11);
        host_cfg(2'd2, 13'h0000);

        // R1, R2, R3, R7: table walk
        for (int i = 0; i < 12; i++) begin
            bus(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25:10]);
            chk($sformatf("R1/R3 vec %0d sel", i), card_sel, VEC[i][9]);
            chk($sformatf("R2/R7 vec %0d oe", i), irq_oe, VEC[i][8:0]);
            chk($sformatf("R8 vec %0d out", i), irq_out, VEC[i][8:0]);
        end

        // R2: every code through the default set
        bus(0, 0, 0, 0, 16'h0000);
        for (int c = 0; c < 16; c++) begin
            dsp_write(3'd1, 13'(c));
            #1;
            chk($sformatf("R2 code %0d oe", c), irq_oe, exp_pins(4'(c)));
            chk($sformatf("R4 code %0d out", c), irq_out, exp_pins(4'(c)));
        end

        // R8: host mask and DSP level
        dsp_write(3'd1, 13'd5);
        host_cfg(2'd2, 13'h0001);
        #1;
        chk("R8 masked out", irq_out, 0);
        chk("R8 masked oe kept", irq_oe, 9'h004);
        host_cfg(2'd2, 13'h0000);
        #1;
        chk("R8 unmasked", irq_out, 9'h004);
        dsp_write(3'd2, 13'h0000);
        #1;
        chk("R8 level low", irq_out, 0);

        // R6: DSP write to plug-and-play set ignored while online
        dsp_write(3'd3, 13'h0100);
        bus(1, 0, 1, 0, 16'hF800);
        chk("R6 online write ignored", card_sel, 1);
        bus(1, 0, 1, 0, 16'h0800);
        chk("R6 online new base unused", card_sel, 0);
        dsp_write(3'd2, 13'h0003);
        dsp_write(3'd3, 13'h0100);
        dsp_write(3'd4, 13'd9);
        bus(1, 0, 1, 0, 16'h0800);
        chk("R6 offline base taken", card_sel, 1);
        chk("R6 offline code taken", irq_oe, 9'h010);
        // R5: host configuration ignored while offline
        host_cfg(2'd0, 13'h1F00);
        host_cfg(2'd1, 13'd3);
        bus(1, 0, 1, 0, 16'h0800);
        chk("R5 host base ignored", card_sel, 1);
        chk("R5 host code ignored", irq_oe, 9'h010);
        chk("R8 offline level", irq_out, 9'h010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule